// File: doc/BRIEF.md
# ATA Programmed-I/O Cycle Timer

This block times the three phases of one parallel ATA programmed-I/O or multiword-DMA transfer: address setup, strobe-active and recovery. Every phase is counted in cycles of the roughly 33 MHz host timing clock (about 30 ns each). A small register file holds compact per-drive timing codes. Each of the four drives has its own active/recovery byte. Drive setup codes are held per drive on channel 0, and the two drives of channel 1 share one setup code.

A requester raises `req` with a drive select and a direction flag. The block latches the decoded counts of that drive at the start of the cycle. It then opens the address-valid window, drives the read or write strobe, and waits out the recovery time. It closes with a one-clock `done` pulse. A request that arrives while a cycle is running is not accepted; a request still held when the cycle finishes starts the next cycle.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset, `addr_valid`, `rd_stb`, `wr_stb` and `done` are low, and every drive times 5 setup clocks, 16 active clocks and 16 recovery clocks.
- R2: The clock after a request is accepted, `addr_valid` rises. After the setup clocks the strobe is high for the active clocks. The strobe is then low for the recovery clocks while `addr_valid` stays high. Then `done` is high for exactly one clock, during which `addr_valid` is low.
- R3: A setup write takes its code from data bits 7:6: code 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5. Data bits 5:0 of a setup write have no effect on timing.
- R4: The active field is bits 7:4 of the active/recovery byte. A value of 0 gives 16 clocks, and any value n from 1 to 15 gives n clocks.
- R5: The recovery field is bits 3:0 of the active/recovery byte. Code 0 gives 16 clocks, code 15 gives 1 clock, and any code n from 1 to 14 gives n+1 clocks.
- R6: Selects are encoded as {channel, drive}, with bit 1 the channel and bit 0 the drive. The four active/recovery bytes are independent. The two drives of channel 0 have independent setup codes.
- R7: A setup write to either drive of channel 1 sets the setup time of both drives of channel 1.
- R8: With `req_read` = 1 the cycle drives `rd_stb`, and with `req_read` = 0 it drives `wr_stb`. The two strobes are never high together.
- R9: A request raised while a cycle is in progress is ignored. A request still high while `done` is high starts a new cycle, with `addr_valid` high in the next clock.
- R10: Register writes made during a cycle do not change that cycle's timing. They take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_setup | input | 1 | Write strobe for the setup code of `cfg_sel` |
| cfg_wr_actrec | input | 1 | Write strobe for the active/recovery byte of `cfg_sel` |
| cfg_sel | input | 2 | Register target, {channel, drive} |
| cfg_data | input | 8 | Write data |
| req | input | 1 | Cycle request |
| req_sel | input | 2 | Drive for the cycle, {channel, drive} |
| req_read | input | 1 | 1 = read cycle, 0 = write cycle |
| addr_valid | output | 1 | Address-valid window |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
Every active code and every recovery code is swept on each of the four drives while the other field is held fixed. This separates the wrap-around endpoints (0 meaning sixteen, 15 meaning one) from the linear middle of each encoding. All four setup codes are written to every setup register with differing low data bits. Cross-drive patterns then show whether channel 0's setup codes stay apart and whether channel 1's shared code follows either drive. Further runs cover a request raised in mid-cycle, a request held across `done`, and a register rewrite during a cycle. These distinguish dropping from queueing, and sampling at cycle start from live reading.

// File: rtl/ata_tim_pkg.sv
package ata_tim_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_REC   = 2'd3
  } phase_t;

  // Setup code to clock count minus one.
  function automatic logic [CNT_W-1:0] setup_m1(input logic [1:0] code);
    case (code)
      2'b01:   setup_m1 = CNT_W'(1);
      2'b10:   setup_m1 = CNT_W'(2);
      2'b00:   setup_m1 = CNT_W'(3);
      default: setup_m1 = CNT_W'(4);
    endcase
  endfunction

  // Active nibble: 0 stands for sixteen, so minus one wraps naturally.
  function automatic logic [CNT_W-1:0] act_m1(input logic [CNT_W-1:0] code);
    act_m1 = code - CNT_W'(1);
  endfunction

  // Recovery nibble: 0 -> 16 clocks, 15 -> 1 clock, n -> n+1 clocks.
  function automatic logic [CNT_W-1:0] rec_m1(input logic [CNT_W-1:0] code);
    if (code == '0)      rec_m1 = '1;
    else if (code == '1) rec_m1 = '0;
    else                 rec_m1 = code;
  endfunction

endpackage

// File: rtl/ata_tim_regs.sv
module ata_tim_regs #(
  parameter int NUM_DRV = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W     = $clog2(NUM_DRV),
  localparam int DRV_CH    = NUM_DRV / 2,
  localparam int NUM_SETUP = DRV_CH + 1,
  localparam int NIB_W     = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_setup,
  input  logic              wr_actrec,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [1:0]        setup_code,
  output logic [NIB_W-1:0]  act_code,
  output logic [NIB_W-1:0]  rec_code
);

  // Channel 0 drives map one-to-one; channel 1 drives share the last slot.
  function automatic int setup_slot(input logic [SEL_W-1:0] s);
    if (s[SEL_W-1]) setup_slot = NUM_SETUP - 1;
    else            setup_slot = int'(s[SEL_W-2:0]);
  endfunction

  logic [1:0]        setup_q [NUM_SETUP];
  logic [DATA_W-1:0] actrec_q [NUM_DRV];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SETUP; i++) setup_q[i] <= 2'b11;
    end else if (wr_setup) begin
      setup_q[setup_slot(wr_sel)] <= wr_data[DATA_W-1 -: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_DRV; i++) actrec_q[i] <= '0;
    end else if (wr_actrec) begin
      actrec_q[wr_sel] <= wr_data;
    end
  end

  assign setup_code = setup_q[setup_slot(rd_sel)];
  assign act_code   = actrec_q[rd_sel][DATA_W-1 -: NIB_W];
  assign rec_code   = actrec_q[rd_sel][NIB_W-1:0];

  // R6: a setup write aimed at channel 0 leaves the shared channel-1 slot alone
  a_r6_ch0_setup_isolated: assert property (@(posedge clk) disable iff (rst)
    (wr_setup && !wr_sel[SEL_W-1]) |=> $stable(setup_q[NUM_SETUP-1]));

  // R7: a setup write aimed at channel 1 leaves channel 0 slot 0 alone
  a_r7_shared_write_isolated: assert property (@(posedge clk) disable iff (rst)
    (wr_setup && wr_sel[SEL_W-1]) |=> $stable(setup_q[0]));

endmodule

// File: rtl/ata_tim_decode.sv
module ata_tim_decode
  import ata_tim_pkg::*;
(
  input  logic [1:0]       setup_code,
  input  logic [CNT_W-1:0] act_code,
  input  logic [CNT_W-1:0] rec_code,
  output logic [CNT_W-1:0] setup_cnt,
  output logic [CNT_W-1:0] act_cnt,
  output logic [CNT_W-1:0] rec_cnt
);

  always_comb begin
    setup_cnt = setup_m1(setup_code);
    act_cnt   = act_m1(act_code);
    rec_cnt   = rec_m1(rec_code);
  end

endmodule

// File: rtl/ata_tim_seq.sv
module ata_tim_seq
  import ata_tim_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_read,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic [CNT_W-1:0] act_cnt,
  input  logic [CNT_W-1:0] rec_cnt,
  output logic             addr_valid,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_l;
  logic [CNT_W-1:0] rec_l;
  logic             is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      act_l      <= '0;
      rec_l      <= '0;
      is_rd      <= 1'b0;
      addr_valid <= 1'b0;
      rd_stb     <= 1'b0;
      wr_stb     <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req) begin
            phase      <= PH_SETUP;
            cnt        <= setup_cnt;
            act_l      <= act_cnt;
            rec_l      <= rec_cnt;
            is_rd      <= req_read;
            addr_valid <= 1'b1;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase  <= PH_ACT;
            cnt    <= act_l;
            rd_stb <= is_rd;
            wr_stb <= !is_rd;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_ACT: begin
          if (cnt == '0) begin
            phase  <= PH_REC;
            cnt    <= rec_l;
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            phase      <= PH_IDLE;
            addr_valid <= 1'b0;
            done       <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));

  a_r2_strobe_in_window: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> addr_valid);

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_done_closes_window: assert property (@(posedge clk) disable iff (rst)
    done |-> (!addr_valid && $past(addr_valid)));

  a_r10_counts_held: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> ($stable(act_l) && $stable(rec_l) && $stable(is_rd)));

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_tim_pkg::*;
#(
  parameter int NUM_DRV = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(NUM_DRV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_setup,
  input  logic              cfg_wr_actrec,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              req,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              req_read,
  output logic              addr_valid,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              done
);

  logic [1:0]       setup_code;
  logic [CNT_W-1:0] act_code, rec_code;
  logic [CNT_W-1:0] setup_cnt, act_cnt, rec_cnt;

  ata_tim_regs #(.NUM_DRV(NUM_DRV), .DATA_W(DATA_W)) i_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_setup   (cfg_wr_setup),
    .wr_actrec  (cfg_wr_actrec),
    .wr_sel     (cfg_sel),
    .wr_data    (cfg_data),
    .rd_sel     (req_sel),
    .setup_code (setup_code),
    .act_code   (act_code),
    .rec_code   (rec_code)
  );

  ata_tim_decode i_decode (
    .setup_code (setup_code),
    .act_code   (act_code),
    .rec_code   (rec_code),
    .setup_cnt  (setup_cnt),
    .act_cnt    (act_cnt),
    .rec_cnt    (rec_cnt)
  );

  ata_tim_seq i_seq (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .req_read   (req_read),
    .setup_cnt  (setup_cnt),
    .act_cnt    (act_cnt),
    .rec_cnt    (rec_cnt),
    .addr_valid (addr_valid),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .done       (done)
  );

endmodule

// File: tb/test_ata_pio_timer.sv
module test_ata_pio_timer;

  localparam time CLK_P = 8ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_setup = 1'b0;
  logic       cfg_wr_actrec = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic       req = 1'b0;
  logic [1:0] req_sel = '0;
  logic       req_read = 1'b0;
  logic       addr_valid, rd_stb, wr_stb, done;

  int n_chk = 0;
  int n_bad = 0;
  int ms, ma, mr;
  bit mstb_ok;

  always #(CLK_P/2) clk = ~clk;

  ata_pio_timer i_ata_pio_timer (
    .clk(clk), .rst(rst),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_actrec(cfg_wr_actrec),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req(req), .req_sel(req_sel), .req_read(req_read),
    .addr_valid(addr_valid), .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
  );

  function automatic int exp_s(input int c);
    return (c == 0) ? 4 : (c == 3) ? 5 : c + 1;
  endfunction
  function automatic int exp_a(input int a);
    return (a == 0) ? 16 : a;
  endfunction
  function automatic int exp_r(input int r);
    return (r == 0) ? 16 : (r == 15) ? 1 : r + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr_setup(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_setup = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr_setup = 1'b0;
  endtask

  task automatic wr_ar(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_actrec = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr_actrec = 1'b0;
  endtask

  // Issues one request and measures the phases at negedges; results in ms/ma/mr.
  task automatic run_cycle(input logic [1:0] sel, input bit rd);
    bit closed_ok;
    ms = 0; ma = 0; mr = 0; mstb_ok = 1'b1;
    @(negedge clk);
    req = 1'b1; req_sel = sel; req_read = rd;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (done) break;
      if (!addr_valid) mstb_ok = 1'b0;
      if (rd_stb && wr_stb) mstb_ok = 1'b0;
      if ((rd && wr_stb) || (!rd && rd_stb)) mstb_ok = 1'b0;
      if (rd_stb || wr_stb) ma++;
      else if (ma == 0) ms++;
      else mr++;
      @(negedge clk);
    end
    closed_ok = done && !addr_valid;
    check(closed_ok, "R2 done with window closed", int'(addr_valid), 0);
  endtask

  task automatic expect_cycle(input string tag, input int s, input int a, input int r);
    check(ms == s, {tag, " setup"}, ms, s);
    check(ma == a, {tag, " active"}, ma, a);
    check(mr == r, {tag, " recovery"}, mr, r);
    check(mstb_ok, {tag, " strobe/window"}, 0, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    check({addr_valid, rd_stb, wr_stb, done} == 4'b0, "R1 outputs idle",
          int'({addr_valid, rd_stb, wr_stb, done}), 0);
    // R1 slowest default timing on every drive
    for (int d = 0; d < 4; d++) begin
      run_cycle(2'(d), 1'b1);
      expect_cycle("R1 default", 5, 16, 16);
    end

    // R4 active sweep, recovery code 3 -> 4 clocks
    for (int d = 0; d < 4; d++) begin
      for (int a = 0; a < 16; a++) begin
        wr_ar(2'(d), {4'(a), 4'd3});
        run_cycle(2'(d), 1'b1);
        expect_cycle("R4 active code", 5, exp_a(a), 4);
      end
    end

    // R5 recovery sweep, active 2, with write direction (R8)
    for (int d = 0; d < 4; d++) begin
      for (int r = 0; r < 16; r++) begin
        wr_ar(2'(d), {4'd2, 4'(r)});
        run_cycle(2'(d), 1'b0);
        expect_cycle("R5 recovery code / R8 write strobe", 5, 2, exp_r(r));
      end
    end

    // R3 setup codes with varied ignored low bits
    for (int d = 0; d < 4; d++) wr_ar(2'(d), 8'h11);
    for (int d = 0; d < 3; d++) begin
      for (int c = 0; c < 4; c++) begin
        wr_setup(2'(d), {2'(c), 6'(c * 13 + d * 7 + 5)});
        run_cycle(2'(d), 1'b1);
        expect_cycle("R3 setup code", exp_s(c), 1, 2);
        wr_setup(2'(d), {2'(c), ~6'(c * 13 + d * 7 + 5)});
        run_cycle(2'(d), 1'b1);
        expect_cycle("R3 low bits ignored", exp_s(c), 1, 2);
      end
    end

    // R6 independent drives
    wr_setup(2'd0, 8'h40);
    wr_setup(2'd1, 8'h80);
    wr_setup(2'd2, 8'h00);
    for (int d = 0; d < 4; d++) wr_ar(2'(d), {4'(d + 1), 4'(d + 1)});
    run_cycle(2'd0, 1'b1); expect_cycle("R6 drive 0", 2, 1, 2);
    run_cycle(2'd1, 1'b1); expect_cycle("R6 drive 1", 3, 2, 3);
    run_cycle(2'd2, 1'b1); expect_cycle("R6 drive 2", 4, 3, 4);
    run_cycle(2'd3, 1'b1); expect_cycle("R6 drive 3", 4, 4, 5);

    // R7 shared setup on channel 1
    wr_setup(2'd2, 8'h40);
    run_cycle(2'd3, 1'b0); expect_cycle("R7 shared via drive 2", 2, 4, 5);
    wr_setup(2'd3, 8'hC0);
    run_cycle(2'd2, 1'b0); expect_cycle("R7 shared via drive 3", 5, 3, 4);
    run_cycle(2'd0, 1'b0); expect_cycle("R7 channel 0 untouched", 2, 1, 2);

    // R9 request during a cycle is dropped
    wr_ar(2'd0, 8'h33);
    @(negedge clk);
    req = 1'b1; req_sel = 2'd0; req_read = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk); @(negedge clk);
    req = 1'b1; req_sel = 2'd1;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 60 && !done; k++) @(negedge clk);
    check(done == 1'b1, "R9 first cycle ends", int'(done), 1);
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (addr_valid) seen++;
      end
      check(seen == 0, "R9 mid-cycle request ignored", seen, 0);
    end

    // R9 held request restarts right after done
    @(negedge clk);
    req = 1'b1; req_sel = 2'd0;
    for (int k = 0; k < 60 && !done; k++) @(negedge clk);
    @(negedge clk);
    check(addr_valid && !done, "R9 held request restarts", int'(addr_valid), 1);
    req = 1'b0;
    for (int k = 0; k < 60 && !done; k++) @(negedge clk);
    @(negedge clk);

    // R10 rewrite during a cycle affects only the next cycle
    fork
      run_cycle(2'd0, 1'b1);
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        cfg_wr_actrec = 1'b1; cfg_sel = 2'd0; cfg_data = 8'h88;
        @(negedge clk);
        cfg_wr_actrec = 1'b0;
      end
    join
    expect_cycle("R10 current cycle keeps old counts", 2, 3, 4);
    run_cycle(2'd0, 1'b1);
    expect_cycle("R10 next cycle uses new counts", 2, 8, 9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule